// File: doc/BRIEF.md
# SPI Slave Register Access Interface

This block is a serial slave endpoint that lets an external SPI master read and write a bank of 64 byte-wide registers. A transaction is one 16-bit frame bracketed by an active-low chip select. The first byte the master sends is a command carrying a register address and a direction flag. The second byte is either write data flowing in on MOSI, or the addressed register's contents flowing out on MISO.

The serial clock, MOSI and chip select are brought into the system clock domain through multi-flop synchronizers. Serial clock edges are then found by comparing the synchronized clock with its value one cycle earlier. The block never generates a serial clock.

There is no back-pressure at the register interface. The master paces every transfer, and the block accepts each bit on the edge it arrives. A write is committed in the system clock cycle after the 16th rising serial clock edge is detected. A plain interrupt output mirrors one chosen bit of one chosen register.

Top module: `spi_reg_slave`

## Requirements
- R1: The block operates in SPI mode 0. It samples MOSI on rising SCK edges, most significant bit first. The command byte is laid out as follows: bits [7:2] hold the register address, bit [1] is the direction flag (1 = write, 0 = read), and bit [0] is unused.
- R2: On a write frame, the second byte is stored into the addressed register once the 16th bit has been received.
- R3: On a read frame, MISO carries 0 during bits 0 to 7. During bits 8 to 15 it carries the addressed register, MSB first, and each bit changes after a falling SCK edge.
- R4: A read frame leaves every register unchanged, whatever data the master sends in its second byte.
- R5: A frame in which chip select returns high before 16 bits have been received writes nothing.
- R6: While chip select is high, MISO is high-impedance when TRISTATE=1, and is driven 0 when TRISTATE=0.
- R7: The interrupt output equals bit IRQ_BIT of register IRQ_ADDR. The defaults are bit 0 of register 1.
- R8: After reset, all registers read 0 and the interrupt output is 0.
- R9: Command bit [0] has no effect. A write whose command has bit [0] set behaves the same as one with the bit clear.
- R10: SCK edges after the 16th within one frame are ignored, so only the first data byte is stored.
- R11: Each new assertion of chip select restarts the frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| irq | output | 1 | Interrupt, mirrors one register bit |

## Verification
A miscounted bit position would appear at the ports within a single frame. It would shift the read-back byte on MISO, or place a write at the wrong address, and the next read of that register exposes it. A bit counter that is not cleared between frames, or a write that is not discarded on abort, shows up as a corrupted value on the next read of the affected register. That read can come as soon as the following frame. A register bank that changes without a write is caught at once on the interrupt pin, or by the next read of the damaged register.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int CMD_W      = 8;
  localparam int FRAME_BITS = CMD_W + DATA_W;
  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
  } cmd_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              csn_s,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wdata,
  output logic              miso_q
);
  logic              sck_d;
  logic              sel, rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-2:0]  in_sr;
  logic [DATA_W-1:0] out_sr;
  cmd_t              cmd_q;

  assign sel  = !csn_s;
  assign rise = sel && sck_s && !sck_d;
  assign fall = sel && !sck_s && sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      in_sr  <= '0;
      out_sr <= '0;
      miso_q <= 1'b0;
      cmd_q  <= '0;
    end else if (!sel) begin
      cnt    <= '0;
      in_sr  <= '0;
      out_sr <= '0;
      miso_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      if (rise && cnt < CNT_W'(FRAME_BITS)) begin
        cnt   <= cnt + 1'b1;
        in_sr <= {in_sr[CMD_W-3:0], mosi_s};
        if (cnt == CNT_W'(CMD_W-1)) begin
          cmd_q.addr <= in_sr[CMD_W-2:1];
          cmd_q.wr   <= in_sr[0];
        end
      end
      if (fall) begin
        if (cnt == CNT_W'(CMD_W)) begin
          if (!cmd_q.wr) begin
            miso_q <= rdata[DATA_W-1];
            out_sr <= {rdata[DATA_W-2:0], 1'b0};
          end
        end else if (cnt > CNT_W'(CMD_W)) begin
          miso_q <= out_sr[DATA_W-1];
          out_sr <= {out_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign addr  = cmd_q.addr;
  assign wdata = {in_sr, mosi_s};
  assign wr_en = rise && cmd_q.wr && (cnt == CNT_W'(FRAME_BITS-1));

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));
  assert_cmd_phase_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < CNT_W'(CMD_W)) |-> !miso_q);
  assert_commit_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == CNT_W'(FRAME_BITS)));
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> (cnt == '0));
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_reg_pkg::*;
#(
  parameter int IRQ_ADDR = 1,
  parameter int IRQ_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= '0;
        else if (we && addr == ADDR_W'(i)) regs[i] <= wdata;
      end
    end
  endgenerate

  assign rdata = regs[addr];
  assign irq_o = regs[IRQ_ADDR][IRQ_BIT];

  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(irq_o));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int IRQ_ADDR    = 1,
  parameter int IRQ_BIT     = 0,
  parameter bit TRISTATE    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic irq
);
  logic              sck_s, mosi_s, csn_s;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wdata, rdata;
  logic              miso_q;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cs_n, sck, mosi}),
    .d_out ({csn_s, sck_s, mosi_s})
  );

  spi_frame u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_s  (sck_s),
    .mosi_s (mosi_s),
    .csn_s  (csn_s),
    .rdata  (rdata),
    .addr   (addr),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .miso_q (miso_q)
  );

  spi_regfile #(.IRQ_ADDR(IRQ_ADDR), .IRQ_BIT(IRQ_BIT)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq_o (irq)
  );

  generate
    if (TRISTATE) begin : g_tri
      assign miso = cs_n ? 1'bz : miso_q;
    end else begin : g_drv
      assign miso = cs_n ? 1'b0 : miso_q;
    end
  endgenerate
endmodule

// File: tb/spi_reg_slave_tb_top.sv
module spi_reg_slave_tb_top;
  localparam int HALF = 8;
  localparam int NV   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  wire  miso;
  wire  irq;
  int   checks = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  spi_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  // {wr, addr[5:0], data[7:0], expected[7:0]}
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 6'h05, 8'hA5, 8'h00},
    {1'b1, 6'h3F, 8'h3C, 8'h00},
    {1'b1, 6'h00, 8'hFF, 8'h00},
    {1'b1, 6'h20, 8'h81, 8'h00},
    {1'b1, 6'h01, 8'h01, 8'h00},
    {1'b0, 6'h05, 8'h55, 8'hA5},
    {1'b0, 6'h3F, 8'h00, 8'h3C},
    {1'b0, 6'h00, 8'h55, 8'hFF},
    {1'b0, 6'h20, 8'hAA, 8'h81},
    {1'b0, 6'h01, 8'h00, 8'h01},
    {1'b0, 6'h05, 8'h00, 8'hA5},
    {1'b0, 6'h04, 8'h00, 8'h00}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [23:0] bits, input int n, output logic [15:0] rx);
    rx = '0;
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      sck  = 1'b0;
      mosi = bits[23-i];
      wait_clk(HALF);
      sck = 1'b1;
      if (i < 16) rx = {rx[14:0], miso};
      wait_clk(HALF);
    end
    sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  function automatic logic [7:0] cmd(input logic wr, input logic [5:0] a, input logic b0);
    return {a, wr, b0};
  endfunction

  initial begin
    wait_clk(200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R8 reset state
    check("R8 irq", {15'd0, irq}, 16'd0);
    frame({cmd(1'b0, 6'h10, 1'b0), 8'h00, 8'h00}, 16, rx);
    check("R8 reg", rx, 16'h0000);
    // R6 release while deselected
    checks++;
    if (miso !== 1'bz) begin fails++; $display("FAIL R6 actual=%b expected=z", miso); end

    // R1 R2 R3 R4 vector walk
    for (int v = 0; v < NV; v++) begin
      frame({cmd(VEC[v][22], VEC[v][21:16], 1'b0), VEC[v][15:8], 8'h00}, 16, rx);
      if (!VEC[v][22]) check($sformatf("R3 R4 vec%0d", v), rx, {8'h00, VEC[v][7:0]});
    end
    check("R7 irq set", {15'd0, irq}, 16'd1);

    // R7 only the selected bit matters
    frame({cmd(1'b1, 6'h01, 1'b0), 8'hFE, 8'h00}, 16, rx);
    check("R7 other bits", {15'd0, irq}, 16'd0);
    frame({cmd(1'b1, 6'h01, 1'b0), 8'h01, 8'h00}, 16, rx);
    check("R7 bit0", {15'd0, irq}, 16'd1);

    // R5 aborted write
    frame({cmd(1'b1, 6'h05, 1'b0), 8'h00, 8'h00}, 12, rx);
    frame({cmd(1'b0, 6'h05, 1'b0), 8'h00, 8'h00}, 16, rx);
    check("R5 abort", rx, 16'h00A5);

    // R11 aborted command then full frame restarts at bit 0
    frame({cmd(1'b1, 6'h06, 1'b0), 8'h00, 8'h00}, 5, rx);
    frame({cmd(1'b1, 6'h06, 1'b0), 8'h6C, 8'h00}, 16, rx);
    frame({cmd(1'b0, 6'h06, 1'b0), 8'h00, 8'h00}, 16, rx);
    check("R11 restart", rx, 16'h006C);

    // R9 command bit 0 ignored
    frame({cmd(1'b1, 6'h07, 1'b1), 8'h5A, 8'h00}, 16, rx);
    frame({cmd(1'b0, 6'h07, 1'b1), 8'h00, 8'h00}, 16, rx);
    check("R9 bit0", rx, 16'h005A);

    // R10 extra clocks ignored
    frame({cmd(1'b1, 6'h08, 1'b0), 8'h12, 8'hEE}, 24, rx);
    frame({cmd(1'b0, 6'h08, 1'b0), 8'h00, 8'h00}, 16, rx);
    check("R10 extra", rx, 16'h0012);

    // R4 reads left neighbours untouched
    frame({cmd(1'b0, 6'h20, 1'b0), 8'h00, 8'h00}, 16, rx);
    check("R4 hold", rx, 16'h0081);

    // R6 after activity
    checks++;
    if (miso !== 1'bz) begin fails++; $display("FAIL R6 actual=%b expected=z", miso); end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule